// File: doc/BRIEF.md
# Charger status pin encoder

This block turns the state of a battery charge controller into drive enables for three open-drain indicator pins: two status pins (A and B) and a power-good pin. Each enable is active low, so a 0 on an output means the open-drain transistor conducts and an attached LED lights. The block sits between the charge state machine and the pad drivers and runs from the system clock.

Two reporting modes exist. In steady mode every fault-like or suspended condition shows as both status pins dark. In blinking mode a group of fault and suspend conditions flash pin A at 0.5 Hz while pin B stays dark. Absent battery and sleep stay fully dark in both modes. A host-controlled configuration input removes the timer-fault indications, because such a charger has no safety timer of its own. A prescaler divides the system clock to the blink half-period. All three outputs come from flip-flops, so a change of the state code cannot glitch a pin.

Top module: `chg_status_enc`

## Requirements
- R1: State code 1 (charging, precharge or fast) with sleep low gives pin A on (`stat_a_n`=0) and pin B off (`stat_b_n`=1), in both modes.
- R2: State code 2 (charge complete) with sleep low gives pin A off and pin B on.
- R3: With `blink_mode`=0, codes 0 (idle), 3 (thermal suspend), 4 (precharge timeout), 5 (fast-charge timeout), 6 (over-voltage), 7 (battery absent), 8 (battery shorted/over-discharged) and the unused codes 9 to 15 give both status pins off.
- R4: With `blink_mode`=1 and sleep low, codes 3, 4, 5 and 8 give pin B off and pin A alternating, on for `BLINK_HALF_CYCLES` clock edges and then off for the same number (1 s each, 0.5 Hz, at the default parameters); moving between these codes keeps the running phase.
- R5: Entering any blinking indication from a non-blinking one starts a new period in the on phase.
- R6: With `blink_mode`=1, codes 0, 6, 7 and 9 to 15 give both status pins off.
- R7: `sleep`=1 forces both status pins and the power-good pin off regardless of code or mode.
- R8: The power-good pin is on (`pgood_n`=0) exactly when `supply_ok`=1 and `sleep`=0.
- R9: With `host_cfg`=1, codes 4 and 5 give both status pins off in both modes; code 3 and 8 still blink in blinking mode.
- R10: Every output is registered: it reflects the inputs sampled at the previous rising clock edge; while `rst_n` is low at an edge all three outputs become 1 (off).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| state_code | input | 4 | Charge controller state code (see R1 to R6) |
| supply_ok | input | 1 | Adapter supply above the sleep-exit threshold |
| sleep | input | 1 | Charger in low-power sleep |
| blink_mode | input | 1 | 1 selects blinking fault indication, 0 steady |
| host_cfg | input | 1 | 1 selects host-controlled configuration without timer faults |
| stat_a_n | output | 1 | Status pin A drive enable, active low |
| stat_b_n | output | 1 | Status pin B drive enable, active low |
| pgood_n | output | 1 | Power-good pin drive enable, active low |

## Verification
The charging and done codes are applied in both modes to show that the two non-fault indications ignore the mode, while every fault code is swept first in steady mode and then in blinking mode, which separates the two fault sets and shows which codes stay dark in both. Blinking codes are held for several half-periods, chained from one to another to show that the phase carries on, and left and re-entered to show the restart in the on phase. Sleep is raised during charging and blinking, and `supply_ok` is toggled alone, to tell the sleep override apart from the power-good rule; the host-controlled setting is run with timer faults and with a thermal suspend to show that only the timer faults lose their flash.

// File: rtl/chg_status_pkg.sv
// Package: shared state codes and indication classes for the status encoder.
// Assumes the charge controller presents a 4-bit state code.
package chg_status_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] SC_IDLE       = 4'd0;
    localparam logic [CODE_W-1:0] SC_CHARGING   = 4'd1;
    localparam logic [CODE_W-1:0] SC_DONE       = 4'd2;
    localparam logic [CODE_W-1:0] SC_TEMP_SUSP  = 4'd3;
    localparam logic [CODE_W-1:0] SC_PRE_TMO    = 4'd4;
    localparam logic [CODE_W-1:0] SC_FAST_TMO   = 4'd5;
    localparam logic [CODE_W-1:0] SC_OVERVOLT   = 4'd6;
    localparam logic [CODE_W-1:0] SC_NO_BATT    = 4'd7;
    localparam logic [CODE_W-1:0] SC_BATT_SHORT = 4'd8;

    // Indication class produced by the decoder
    typedef enum logic [1:0] {
        IND_DARK  = 2'd0,
        IND_PIN_A = 2'd1,
        IND_PIN_B = 2'd2,
        IND_FLASH = 2'd3
    } ind_e;

endpackage

// File: rtl/chg_state_decode.sv
// Module: maps state code, sleep, mode and configuration to an indication class.
// Purely combinational; assumes the caller registers its result.
module chg_state_decode
    import chg_status_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              sleep,
    input  logic              blink_mode,
    input  logic              host_cfg,
    output ind_e              ind
);

    logic flash_timer_ok;

    // Timer-fault flashing exists only in blinking mode and without host control
    assign flash_timer_ok = blink_mode && !host_cfg;

    // Select the indication class for the present inputs
    always_comb begin
        ind = IND_DARK;
        if (!sleep) begin
            case (code)
                SC_CHARGING:   ind = IND_PIN_A;
                SC_DONE:       ind = IND_PIN_B;
                SC_TEMP_SUSP,
                SC_BATT_SHORT: ind = blink_mode     ? IND_FLASH : IND_DARK;
                SC_PRE_TMO,
                SC_FAST_TMO:   ind = flash_timer_ok ? IND_FLASH : IND_DARK;
                default:       ind = IND_DARK;
            endcase
        end
    end

endmodule

// File: rtl/chg_blink_timer.sv
// Module: prescaler producing the flash phase for blinking indications.
// Holds the on phase while no flash is requested, so each flash starts lit.
// Assumes HALF_CYCLES >= 1 clock edges per half-period.
module chg_blink_timer #(
    parameter int HALF_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic phase_on
);

    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count edges of a half-period and flip the phase at its end
    always_ff @(posedge clk) begin
        if (!rst_n || !req) begin
            cnt      <= '0;
            phase_on <= 1'b1;
        end else if (cnt == LAST) begin
            cnt      <= '0;
            phase_on <= !phase_on;
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/chg_pin_regs.sv
// Module: output flip-flops for the three active-low pin enables.
// Assumes the indication class and phase are stable before the clock edge.
module chg_pin_regs
    import chg_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ind_e ind,
    input  logic phase_on,
    input  logic pg_req,
    output logic stat_a_n,
    output logic stat_b_n,
    output logic pgood_n
);

    logic a_lit;
    logic b_lit;

    // Pin A lights when steady-on or when flashing in its on phase
    assign a_lit = (ind == IND_PIN_A) || ((ind == IND_FLASH) && phase_on);
    assign b_lit = (ind == IND_PIN_B);

    // Register the enables so code transitions cannot glitch the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_a_n <= 1'b1;
            stat_b_n <= 1'b1;
            pgood_n  <= 1'b1;
        end else begin
            stat_a_n <= !a_lit;
            stat_b_n <= !b_lit;
            pgood_n  <= !pg_req;
        end
    end

endmodule

// File: rtl/chg_status_enc.sv
// Module: charger status pin encoder top level.
// Decodes the controller state, runs the flash prescaler and registers the
// three open-drain enables. Assumes all inputs are synchronous to clk.
module chg_status_enc
    import chg_status_pkg::*;
#(
    parameter int BLINK_HALF_CYCLES = 25_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] state_code,
    input  logic              supply_ok,
    input  logic              sleep,
    input  logic              blink_mode,
    input  logic              host_cfg,
    output logic              stat_a_n,
    output logic              stat_b_n,
    output logic              pgood_n
);

    ind_e ind;
    logic flash_req;
    logic phase_on;
    logic pg_req;

    assign flash_req = (ind == IND_FLASH);
    assign pg_req    = supply_ok && !sleep;

    chg_state_decode u_decode (
        .code       (state_code),
        .sleep      (sleep),
        .blink_mode (blink_mode),
        .host_cfg   (host_cfg),
        .ind        (ind)
    );

    chg_blink_timer #(
        .HALF_CYCLES (BLINK_HALF_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (flash_req),
        .phase_on (phase_on)
    );

    chg_pin_regs u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .ind      (ind),
        .phase_on (phase_on),
        .pg_req   (pg_req),
        .stat_a_n (stat_a_n),
        .stat_b_n (stat_b_n),
        .pgood_n  (pgood_n)
    );

endmodule

// File: rtl/chg_status_chk.sv
// Module: assertion checker for the status encoder, bound to the top level.
// Relates sampled inputs to the registered pin enables one edge later.
module chg_status_chk
    import chg_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] state_code,
    input logic              supply_ok,
    input logic              sleep,
    input logic              blink_mode,
    input logic              host_cfg,
    input logic              stat_a_n,
    input logic              stat_b_n,
    input logic              pgood_n
);

    assert_charging_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == SC_CHARGING && !sleep) |=> (!stat_a_n && stat_b_n));

    assert_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == SC_DONE && !sleep) |=> (stat_a_n && !stat_b_n));

    assert_steady_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blink_mode && state_code != SC_CHARGING && state_code != SC_DONE)
        |=> (stat_a_n && stat_b_n));

    assert_flash_b_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_mode && (state_code == SC_TEMP_SUSP || state_code == SC_BATT_SHORT))
        |=> stat_b_n);

    assert_blink_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_mode && (state_code == SC_NO_BATT || state_code == SC_OVERVOLT))
        |=> (stat_a_n && stat_b_n));

    assert_sleep_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (stat_a_n && stat_b_n && pgood_n));

    assert_pgood_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !sleep) |=> !pgood_n);

    assert_pgood_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> pgood_n);

    assert_host_no_tmr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cfg && (state_code == SC_PRE_TMO || state_code == SC_FAST_TMO))
        |=> (stat_a_n && stat_b_n));

    assert_never_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!stat_a_n, !stat_b_n}) <= 1);

endmodule

bind chg_status_enc chg_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_code (state_code),
    .supply_ok  (supply_ok),
    .sleep      (sleep),
    .blink_mode (blink_mode),
    .host_cfg   (host_cfg),
    .stat_a_n   (stat_a_n),
    .stat_b_n   (stat_b_n),
    .pgood_n    (pgood_n)
);

// File: tb/sim_chg_status_enc.sv
// Bench: behavioural reference model compared against the pins on every clock.
module sim_chg_status_enc;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] state_code = 4'd0;
    logic       supply_ok = 1'b0;
    logic       sleep = 1'b0;
    logic       blink_mode = 1'b0;
    logic       host_cfg = 1'b0;
    logic       stat_a_n;
    logic       stat_b_n;
    logic       pgood_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    chg_status_enc #(.BLINK_HALF_CYCLES(HALF)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_code (state_code),
        .supply_ok  (supply_ok),
        .sleep      (sleep),
        .blink_mode (blink_mode),
        .host_cfg   (host_cfg),
        .stat_a_n   (stat_a_n),
        .stat_b_n   (stat_b_n),
        .pgood_n    (pgood_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    logic  exp_a = 1'b1, exp_b = 1'b1, exp_pg = 1'b1;
    int    run   = 0;
    bit    primed = 0;
    string tag   = "R10";

    // Model: class per requirement, flash phase from consecutive flashing edges
    always @(posedge clk) begin
        primed = 1;
        if (!rst_n) begin
            exp_a = 1; exp_b = 1; exp_pg = 1; run = 0; tag = "R10";
        end else begin
            bit flash;
            flash  = 0;
            exp_a  = 1; exp_b = 1;
            exp_pg = (supply_ok && !sleep) ? 1'b0 : 1'b1;
            if (sleep) tag = "R7";
            else if (state_code == 4'd1) begin exp_a = 0; tag = "R1"; end
            else if (state_code == 4'd2) begin exp_b = 0; tag = "R2"; end
            else if (!blink_mode) tag = "R3";
            else if (state_code == 4'd3 || state_code == 4'd8) flash = 1;
            else if (state_code == 4'd4 || state_code == 4'd5) begin
                if (host_cfg) tag = "R9"; else flash = 1;
            end else tag = "R6";
            if (flash) begin
                tag   = (run == 0) ? "R5" : "R4";
                exp_a = (((run / HALF) % 2) == 0) ? 1'b0 : 1'b1;
                run++;
            end else begin
                run = 0;
            end
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (primed && !done) begin
            total++;
            if (stat_a_n !== exp_a || stat_b_n !== exp_b) begin
                bad++;
                $display("FAIL %s status a/b actual=%b%b expected=%b%b code=%0d t=%0t",
                         tag, stat_a_n, stat_b_n, exp_a, exp_b, state_code, $time);
            end
            total++;
            if (pgood_n !== exp_pg) begin
                bad++;
                $display("FAIL %s pgood actual=%b expected=%b t=%0t",
                         (sleep ? "R7" : "R8"), pgood_n, exp_pg, $time);
            end
        end
    end

    task automatic apply(input logic [3:0] c, input logic bm, input logic hc,
                         input logic sup, input logic slp, input int n);
        @(negedge clk);
        state_code = c; blink_mode = bm; host_cfg = hc;
        supply_ok = sup; sleep = slp;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R10 watchdog actual=timeout expected=finished");
            finish_run();
        end
    end

    initial begin
        // R10: reset state, driven inputs ignored while in reset
        state_code = 4'd1; supply_ok = 1; blink_mode = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1, R2 in both modes
        apply(4'd1, 0, 0, 1, 0, 4);
        apply(4'd2, 0, 0, 1, 0, 4);
        apply(4'd1, 1, 0, 1, 0, 4);
        apply(4'd2, 1, 0, 1, 0, 4);
        // R3: steady mode sweep of every other code
        for (int c = 0; c < 16; c++)
            if (c != 1 && c != 2) apply(4'(c), 0, 0, 1, 0, 3);
        // R4, R5: each flashing code, several half-periods
        apply(4'd3, 1, 0, 1, 0, 4*HALF);
        apply(4'd1, 1, 0, 1, 0, 2);
        apply(4'd8, 1, 0, 1, 0, 3*HALF);
        apply(4'd0, 1, 0, 1, 0, 2);
        apply(4'd4, 1, 0, 1, 0, 3*HALF);
        apply(4'd5, 1, 0, 1, 0, 3*HALF + 1);
        // R4: chaining flash codes keeps the phase, mid-period changes
        apply(4'd3, 1, 0, 1, 0, HALF/2);
        apply(4'd8, 1, 0, 1, 0, HALF);
        apply(4'd4, 1, 0, 1, 0, HALF + 2);
        // R5: leave for a dark code and re-enter in the off phase
        apply(4'd7, 1, 0, 1, 0, 1);
        apply(4'd3, 1, 0, 1, 0, 2*HALF);
        // R6: blinking-mode dark codes
        for (int c = 0; c < 16; c++)
            if (c == 0 || c == 6 || c == 7 || c > 8) apply(4'(c), 1, 0, 1, 0, 3);
        // R7: sleep over charging, done and flashing
        apply(4'd1, 0, 0, 1, 1, 4);
        apply(4'd2, 1, 0, 1, 1, 4);
        apply(4'd8, 1, 0, 1, 1, 4);
        apply(4'd8, 1, 0, 1, 0, HALF + 2);
        // R8: supply toggled alone
        apply(4'd1, 0, 0, 0, 0, 4);
        apply(4'd1, 0, 0, 1, 0, 4);
        apply(4'd1, 0, 0, 0, 1, 4);
        // R9: host-controlled configuration
        apply(4'd4, 1, 1, 1, 0, 2*HALF);
        apply(4'd5, 1, 1, 1, 0, 2*HALF);
        apply(4'd5, 0, 1, 1, 0, 3);
        apply(4'd3, 1, 1, 1, 0, 3*HALF);
        apply(4'd8, 1, 1, 1, 0, HALF);
        // R10: reset mid-flash returns all pins off
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        apply(4'd3, 1, 0, 1, 0, 2*HALF);
        finish_run();
    end

endmodule